// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received frame's destination MAC address passes the multicast hash filter. It takes a 12-bit slice of the 48-bit address and uses it as an index into a 4096-bit acceptance table. A 2-bit mode input picks one of four slice positions. The table is held as 128 words of 32 bits. The upper seven bits of the index pick the word and the lower five bits pick the bit inside that word.

Software writes the table through a word port. It can also set a single bit by index, or clear the whole table in one cycle, and it can read any word back combinationally. For each frame the receive path presents the destination address with a valid strobe. One cycle later the block returns a registered result. The result has a hash-hit flag and a separate broadcast flag. The broadcast flag is raised for the all-ones address, which never uses the table.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset every table word reads zero, and `res_valid`, `res_hash_hit` and `res_bcast` are 0.
- R2: The hash index is a 12-bit slice of `lk_dst`, chosen by `hash_mode`: 0 takes bits [47:36], 1 takes [46:35], 2 takes [45:34] and 3 takes [43:32]. Address byte k sits in bits [8k+7:8k], and byte 0 is sent first.
- R3: Index bits [11:5] select table word 0..127 and index bits [4:0] select the bit inside it. `tbl_wr` stores `tbl_wdata` into word `tbl_waddr`, and `tbl_rdata` shows word `tbl_raddr` in the same cycle.
- R4: While `hash_en` is 0, `res_hash_hit` stays 0 for every address.
- R5: An address with bit 0 of `lk_dst` equal to 0 (not multicast) never gives `res_hash_hit`.
- R6: The address 48'hFFFF_FFFF_FFFF gives `res_bcast`=1 and `res_hash_hit`=0, whatever the table holds. `res_bcast` is 0 for every other address.
- R7: `tbl_clear` sets all 128 words to zero.
- R8: `tbl_set` ORs the one bit addressed by `tbl_set_idx` into the table and leaves every other bit unchanged.
- R9: Results are registered. `res_valid` is high exactly one cycle after `lk_valid`. When `res_valid` is 0, both flags are 0.
- R10: A lookup always sees the table as it stood before any update made in the same cycle.
- R11: When table updates coincide, clear wins over word write, and word write wins over bit set. Only the winning update takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hash_en | input | 1 | Multicast hash filtering enable |
| hash_mode | input | 2 | Slice position select |
| tbl_clear | input | 1 | Clear whole table |
| tbl_wr | input | 1 | Word write strobe |
| tbl_waddr | input | 7 | Word write address |
| tbl_wdata | input | 32 | Word write data |
| tbl_set | input | 1 | Single-bit set strobe |
| tbl_set_idx | input | 12 | Bit index to set |
| tbl_raddr | input | 7 | Readback word address |
| tbl_rdata | output | 32 | Readback word data |
| lk_valid | input | 1 | Lookup strobe |
| lk_dst | input | 48 | Destination address to test |
| res_valid | output | 1 | Result valid, one cycle after `lk_valid` |
| res_hash_hit | output | 1 | Address matched through the table |
| res_bcast | output | 1 | Address was broadcast |

## Verification
A lookup and a table update can land in the same cycle, including a clear, or a set of the very bit being looked up. The bench drives random mixes of lookups, clears, word writes and bit sets together in single cycles, plus directed cases where a clear or a set hits the bit under lookup. Its model computes the expected result from the table state before that cycle's update (R10). It then applies only the winning update (R11) and compares later readbacks and lookups against that model.

// File: rtl/mhf_pkg.sv
// Package: shared sizes and the hash-slice function for the multicast
// hash filter. Assumes a 48-bit address with byte 0 in bits [7:0].
package mhf_pkg;
    localparam int ADDR_W = 48;
    localparam int HASH_W = 12;

    // Pick the 12-bit hash slice named by the mode.
    function automatic logic [HASH_W-1:0] hash_slice(input logic [ADDR_W-1:0] a,
                                                     input logic [1:0] mode);
        logic [HASH_W-1:0] v;
        case (mode)
            2'd0:    v = a[47:36];
            2'd1:    v = a[46:35];
            2'd2:    v = a[45:34];
            default: v = a[43:32];
        endcase
        return v;
    endfunction
endpackage

// File: rtl/mhf_hash.sv
// Module: mhf_hash
// Purely combinational front end. It forms the table index and classifies
// the address (multicast or broadcast). Assumes the multicast flag is bit 0
// of the first transmitted byte.
module mhf_hash
    import mhf_pkg::*;
(
    input  logic [ADDR_W-1:0] dst,
    input  logic [1:0]        mode,
    output logic [HASH_W-1:0] idx,
    output logic              is_mcast,
    output logic              is_bcast
);
    // Classify the address and slice out the index.
    always_comb begin
        idx      = hash_slice(dst, mode);
        is_bcast = &dst;
        is_mcast = dst[0];
    end
endmodule

// File: rtl/mhf_table.sv
// Module: mhf_table
// The hash table as NWORDS words of WORD_W bits. It has one update port
// (clear > write > set) and two combinational read ports: the lookup bit
// and the readback word. Reads return the contents before this cycle's update.
module mhf_table #(
    parameter int HASH_W = 12,
    parameter int WORD_W = 32,
    localparam int BIT_W  = $clog2(WORD_W),
    localparam int ROW_W  = HASH_W - BIT_W,
    localparam int NWORDS = 1 << ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [ROW_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              set,
    input  logic [HASH_W-1:0] set_idx,
    input  logic [ROW_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata,
    input  logic [HASH_W-1:0] lk_idx,
    output logic              lk_bit
);
    logic [WORD_W-1:0] mem [NWORDS];

    // Apply the winning table update, or zero the table on reset.
    always_ff @(posedge clk) begin
        for (int w = 0; w < NWORDS; w++) begin
            if (!rst_n || clr) begin
                mem[w] <= '0;
            end else if (wr) begin
                if (waddr == ROW_W'(w)) mem[w] <= wdata;
            end else if (set) begin
                if (set_idx[HASH_W-1:BIT_W] == ROW_W'(w))
                    mem[w] <= mem[w] | (WORD_W'(1) << set_idx[BIT_W-1:0]);
            end
        end
    end

    // Read ports see the pre-update contents.
    always_comb begin
        rdata  = mem[raddr];
        lk_bit = mem[lk_idx[HASH_W-1:BIT_W]][lk_idx[BIT_W-1:0]];
    end

    // A clear leaves every word zero on the next cycle.
    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rdata == '0));

    // A lone set leaves its bit high.
    p_set_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !wr && !clr) |=>
        mem[$past(set_idx[HASH_W-1:BIT_W])][$past(set_idx[BIT_W-1:0])]);

    // A word write beats a coincident set.
    p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/mcast_hash_filter.sv
// Module: mcast_hash_filter
// Top of the multicast hash filter. It hashes the lookup address, reads
// the table and registers the hit and broadcast flags one cycle after
// lk_valid. Assumes mode and enable are stable while a lookup is presented.
module mcast_hash_filter
    import mhf_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int BIT_W = $clog2(WORD_W),
    localparam int ROW_W = HASH_W - BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hash_en,
    input  logic [1:0]        hash_mode,
    input  logic              tbl_clear,
    input  logic              tbl_wr,
    input  logic [ROW_W-1:0]  tbl_waddr,
    input  logic [WORD_W-1:0] tbl_wdata,
    input  logic              tbl_set,
    input  logic [HASH_W-1:0] tbl_set_idx,
    input  logic [ROW_W-1:0]  tbl_raddr,
    output logic [WORD_W-1:0] tbl_rdata,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_dst,
    output logic              res_valid,
    output logic              res_hash_hit,
    output logic              res_bcast
);
    logic [HASH_W-1:0] idx;
    logic              is_mcast, is_bcast, tbl_bit;

    mhf_hash u_hash (
        .dst      (lk_dst),
        .mode     (hash_mode),
        .idx      (idx),
        .is_mcast (is_mcast),
        .is_bcast (is_bcast)
    );

    mhf_table #(.HASH_W(HASH_W), .WORD_W(WORD_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tbl_clear),
        .wr      (tbl_wr),
        .waddr   (tbl_waddr),
        .wdata   (tbl_wdata),
        .set     (tbl_set),
        .set_idx (tbl_set_idx),
        .raddr   (tbl_raddr),
        .rdata   (tbl_rdata),
        .lk_idx  (idx),
        .lk_bit  (tbl_bit)
    );

    // Register the lookup result; flags are forced low when no lookup is made.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_hash_hit <= 1'b0;
            res_bcast    <= 1'b0;
        end else begin
            res_valid    <= lk_valid;
            res_bcast    <= lk_valid && is_bcast;
            res_hash_hit <= lk_valid && hash_en && is_mcast && !is_bcast && tbl_bit;
        end
    end

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_hash_hit && !res_bcast));

    p_hit_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_hash_hit |-> $past(hash_en));

    p_hit_needs_mcast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_hash_hit |-> $past(lk_dst[0]));

    p_bcast_no_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_bcast |-> !res_hash_hit);
endmodule

// File: tb/tb_mcast_hash_filter.sv
module tb_mcast_hash_filter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        hash_en;
    logic [1:0]  hash_mode;
    logic        tbl_clear, tbl_wr, tbl_set, lk_valid;
    logic [6:0]  tbl_waddr, tbl_raddr;
    logic [31:0] tbl_wdata, tbl_rdata;
    logic [11:0] tbl_set_idx;
    logic [47:0] lk_dst;
    logic        res_valid, res_hash_hit, res_bcast;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model [128];

    always #2.5 clk = ~clk;

    mcast_hash_filter dut (.*);

    function automatic logic [11:0] exp_idx(input logic [47:0] a, input logic [1:0] m);
        logic [7:0] b4, b5;
        b4 = a[39:32];
        b5 = a[47:40];
        case (m)
            2'd0:    return 12'((b4 >> 4) | ({4'b0, b5} << 4));
            2'd1:    return 12'((b4 >> 3) | ({4'b0, b5} << 5));
            2'd2:    return 12'((b4 >> 2) | ({4'b0, b5} << 6));
            default: return 12'(b4 | ({4'b0, b5} << 8));
        endcase
    endfunction

    function automatic logic exp_hit(input logic [47:0] a, input logic [1:0] m, input logic en);
        logic [11:0] v;
        v = exp_idx(a, m);
        return en && a[0] && !(&a) && model[v[11:5]][v[4:0]];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // One cycle of stimulus driven at a negedge, checked at the next negedge.
    task automatic step(input string req, input logic clr, input logic wr,
                        input logic [6:0] wa, input logic [31:0] wd,
                        input logic st, input logic [11:0] si,
                        input logic lk, input logic [47:0] a);
        logic eh, eb;
        eh = lk && exp_hit(a, hash_mode, hash_en);   // pre-update table (R10)
        eb = lk && (&a);
        tbl_clear = clr; tbl_wr = wr; tbl_waddr = wa; tbl_wdata = wd;
        tbl_set = st; tbl_set_idx = si; lk_valid = lk; lk_dst = a;
        if (clr) begin
            for (int w = 0; w < 128; w++) model[w] = '0;
        end else if (wr) begin
            model[wa] = wd;
        end else if (st) begin
            model[si[11:5]][si[4:0]] = 1'b1;
        end
        @(negedge clk);
        tbl_clear = 0; tbl_wr = 0; tbl_set = 0; lk_valid = 0;
        chk({req, " R9 valid"}, 32'(res_valid), 32'(lk));
        chk({req, " hit"}, 32'(res_hash_hit), 32'(eh));
        chk({req, " R6 bcast"}, 32'(res_bcast), 32'(eb));
    endtask

    task automatic readback(input string req, input logic [6:0] ra);
        tbl_raddr = ra;
        #1;
        chk({req, " rdata"}, tbl_rdata, model[ra]);
    endtask

    task automatic lookup(input string req, input logic [47:0] a);
        step(req, 0, 0, 0, 0, 0, 0, 1, a);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [47:0] a, b;
        logic [11:0] v;
        void'($urandom(32'h5eed_1234));
        for (int w = 0; w < 128; w++) model[w] = '0;
        rst_n = 0; hash_en = 1; hash_mode = 0;
        tbl_clear = 0; tbl_wr = 0; tbl_set = 0; lk_valid = 0;
        tbl_waddr = 0; tbl_wdata = 0; tbl_set_idx = 0; tbl_raddr = 0; lk_dst = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 res_valid", 32'(res_valid), 0);
        chk("R1 hit", 32'(res_hash_hit), 0);
        chk("R1 bcast", 32'(res_bcast), 0);
        readback("R1", 0);
        readback("R1", 127);
        rst_n = 1;
        @(negedge clk);

        // R2/R8: each mode hits on its own slice
        for (int m = 0; m < 4; m++) begin
            hash_mode = 2'(m);
            a = 48'h5A3C_9E71_2B01 ^ (48'(m) << 40);
            v = exp_idx(a, hash_mode);
            step("R7", 1, 0, 0, 0, 0, 0, 0, 0);
            step("R8 set", 0, 0, 0, 0, 1, v, 0, 0);
            lookup("R2 mode hit", a);
            b = a ^ (48'h1 << (47 - (m == 3 ? 4 : m)));
            lookup("R2 slice miss", b);
            readback("R3 R8", v[11:5]);
        end
        hash_mode = 0;
        a = 48'h1234_5678_9A01;
        v = exp_idx(a, 0);
        step("R8", 0, 0, 0, 0, 1, v, 0, 0);
        // R4: disabled
        hash_en = 0;
        lookup("R4 disabled", a);
        hash_en = 1;
        lookup("R4 enabled", a);
        // R5: unicast with same hash bits
        lookup("R5 unicast", a & ~48'h1);
        // R6: broadcast with its table word all ones
        step("R3 wr", 0, 1, 127, 32'hFFFF_FFFF, 0, 0, 0, 0);
        lookup("R6 broadcast", {48{1'b1}});
        // R3/R8: write word then OR one bit
        step("R3 wr", 0, 1, 7'd33, 32'hA5A5_0F0F, 0, 0, 0, 0);
        readback("R3", 33);
        step("R8 or", 0, 0, 0, 0, 1, {7'd33, 5'd4}, 0, 0);
        readback("R8 keep", 33);
        // R10: clear in the lookup cycle still sees old bit
        step("R10 clr+lk", 1, 0, 0, 0, 0, 0, 1, a);
        lookup("R10 after clr", a);
        readback("R7", 33);
        readback("R7", 127);
        // R10: set in lookup cycle not seen yet
        step("R10 set+lk", 0, 0, 0, 0, 1, v, 1, a);
        lookup("R10 after set", a);
        // R11 priorities
        step("R11 clr+wr", 1, 1, 7'd5, 32'hDEAD_BEEF, 0, 0, 0, 0);
        readback("R11 clr wins", 5);
        step("R11 wr+set", 0, 1, 7'd5, 32'h0000_0001, 1, {7'd5, 5'd31}, 0, 0);
        readback("R11 wr wins", 5);
        // R9: idle cycle
        step("R9 idle", 0, 0, 0, 0, 0, 0, 0, 0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic clr, wr, st, lk;
            logic [47:0] ra;
            hash_mode = 2'($urandom);
            hash_en   = ($urandom % 8) != 0;
            clr = ($urandom % 40) == 0;
            wr  = ($urandom % 3) == 0;
            st  = ($urandom % 3) == 0;
            lk  = ($urandom % 4) != 0;
            ra  = {$urandom, $urandom}[47:0];
            if (($urandom % 30) == 0) ra = {48{1'b1}};
            step("R10 R11 rand", clr, wr, 7'($urandom), $urandom, st, 12'($urandom), lk, ra);
            if ((i % 16) == 0) readback("R3 rand", 7'($urandom));
        end
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule